// File: doc/BRIEF.md
# Normalized Patch Prototype Correlator

This block scores one square window of oriented feature values against one stored template of the same shape. A caller streams the window's feature values, each paired with the matching template value. The block sums the element products into a single correlation total that covers every position and every orientation plane. Alongside that total it sums the squares of the window's own values, which gives the patch energy. It then takes the integer square root of the energy. The correlation, the energy and the root come out together, so the caller can divide by the patch norm.

The window edge is chosen for each patch from four sizes. Every window position carries twelve orientation values. The block clears its sums at the first element of each patch. It closes the patch by itself once it has accepted the full element count. The same instance can therefore be swept over many templates and many image scales with nothing to reconfigure.

Top module: `patch_corr`

## Requirements
- R1: After a synchronous active-high reset, in_ready is 1 and out_valid is 0.
- R2: The 2-bit size code is sampled only with the first element of a patch. Code 0 selects edge 4, code 1 selects 8, code 2 selects 12 and code 3 selects 16. The patch closes after exactly edge*edge*12 accepted elements.
- R3: out_dot equals the sum of in_patch*in_proto over all accepted elements of the patch. Both inputs are unsigned 16-bit values. The sum is exact in 48 bits, even for a 16-edge patch with every input at 0xFFFF.
- R4: out_energy equals the sum of in_patch squared over the same elements.
- R5: out_root equals floor(sqrt(out_energy)). out_valid rises on the 24th rising edge after the edge that accepted the last element of the patch.
- R6: out_zero is 1 when the reported energy is zero, and 0 otherwise.
- R7: in_ready is 0 from the acceptance of the last element until the edge where out_valid and out_ready are both 1. While out_valid is 1 and out_ready is 0, all result outputs hold their values.
- R8: While no patch is open, an accepted element without in_first is discarded. Within an open patch, in_first and in_size are ignored.
- R9: Each patch's results depend only on its own elements, even when patches follow back to back.
- R10: Cycles with in_valid low inside a patch add nothing and do not advance the element count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An element is offered |
| in_ready | output | 1 | The block can take an element |
| in_first | input | 1 | Marks the first element of a patch |
| in_size | input | 2 | Window edge code, sampled with the first element |
| in_patch | input | 16 | Patch feature value, unsigned |
| in_proto | input | 16 | Template value paired with in_patch, unsigned |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_dot | output | 48 | Correlation sum |
| out_energy | output | 48 | Sum of squared patch values |
| out_root | output | 24 | Integer square root of the energy |
| out_zero | output | 1 | Energy is zero, so the caller skips the division |

## Verification
The assertions assume the producer marks each patch's start with in_first and supplies unsigned values that never exceed 16 bits. Under those conditions the element count stays below the patch total, and the energy never falls while a patch is being summed. The stimulus keeps to this. Each patch starts with a flagged element, and every value comes from a 16-bit range. A stray first flag is sent mid-patch and a stray unflagged element is sent while idle, so the ignore rules are exercised. The consumer stalls for several cycles so that the result hold can be observed.

// File: rtl/corr_pkg.sv
package corr_pkg;
    localparam int DW     = 16;
    localparam int AW     = 48;
    localparam int ORIENT = 12;
    localparam int RW     = AW / 2;
    localparam int RMW    = RW + 4;
    localparam int MAXN   = 16;
    localparam int CW     = $clog2(MAXN * MAXN * ORIENT + 1);

    typedef enum logic [1:0] {EDGE4, EDGE8, EDGE12, EDGE16} edge_code_t;
    typedef enum logic [1:0] {PH_IDLE, PH_SUM, PH_WAIT} phase_t;

    typedef struct packed {
        logic [RMW-1:0] rem;
        logic [RW-1:0]  root;
    } sq_state_t;

    function automatic logic [CW-1:0] patch_elems(edge_code_t c);
        int n;
        n = (int'(c) + 1) * 4;
        return CW'(n * n * ORIENT);
    endfunction

    function automatic sq_state_t sq_step(sq_state_t s, logic [1:0] pair);
        sq_state_t      nx;
        logic [RMW-1:0] shifted;
        logic [RMW-1:0] trial;
        shifted = {s.rem[RMW-3:0], pair};
        trial   = RMW'({s.root, 2'b01});
        if (shifted >= trial) begin
            nx.rem  = shifted - trial;
            nx.root = {s.root[RW-2:0], 1'b1};
        end else begin
            nx.rem  = shifted;
            nx.root = {s.root[RW-2:0], 1'b0};
        end
        return nx;
    endfunction
endpackage

// File: rtl/corr_accum.sv
module corr_accum
    import corr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_first,
    input  logic [1:0]    in_size,
    input  logic [DW-1:0] in_patch,
    input  logic [DW-1:0] in_proto,
    input  logic          res_taken,
    output logic          in_ready,
    output logic [AW-1:0] dot,
    output logic [AW-1:0] energy,
    output logic          done
);
    phase_t          phase;
    logic [CW-1:0]   count;
    logic [CW-1:0]   total;
    logic [2*DW-1:0] prod_pq;
    logic [2*DW-1:0] prod_pp;
    logic            take;

    assign in_ready = (phase != PH_WAIT);
    assign take     = in_valid && in_ready;
    assign prod_pq  = in_patch * in_proto;
    assign prod_pp  = in_patch * in_patch;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            count  <= '0;
            total  <= '0;
            dot    <= '0;
            energy <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: if (take && in_first) begin
                    dot    <= AW'(prod_pq);
                    energy <= AW'(prod_pp);
                    count  <= CW'(1);
                    total  <= patch_elems(edge_code_t'(in_size));
                    phase  <= PH_SUM;
                end
                PH_SUM: if (take) begin
                    dot    <= dot + AW'(prod_pq);
                    energy <= energy + AW'(prod_pp);
                    count  <= count + CW'(1);
                    if (count + CW'(1) == total) begin
                        phase <= PH_WAIT;
                        done  <= 1'b1;
                    end
                end
                PH_WAIT: if (res_taken) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2: an open patch never reaches its own total before closing
    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SUM) |-> (count < total));

    // R4: energy only grows while a patch is being summed
    p_energy_grows_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SUM && take) |=> (energy >= $past(energy)));
endmodule

// File: rtl/corr_isqrt.sv
module corr_isqrt
    import corr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] radicand,
    input  logic          take,
    output logic          valid,
    output logic [RW-1:0] root,
    output logic          zero
);
    localparam int SCW = $clog2(RW + 1);

    sq_state_t      st;
    sq_state_t      st_from_start;
    sq_state_t      st_from_busy;
    logic [AW-1:0]  pending;
    logic [SCW-1:0] steps;
    logic           busy;

    assign st_from_start = sq_step('0, radicand[AW-1:AW-2]);
    assign st_from_busy  = sq_step(st, pending[AW-1:AW-2]);
    assign root          = st.root;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            pending <= '0;
            steps   <= '0;
            busy    <= 1'b0;
            valid   <= 1'b0;
            zero    <= 1'b0;
        end else if (start) begin
            st      <= st_from_start;
            pending <= {radicand[AW-3:0], 2'b00};
            steps   <= SCW'(1);
            busy    <= 1'b1;
            zero    <= (radicand == '0);
        end else if (busy) begin
            st      <= st_from_busy;
            pending <= {pending[AW-3:0], 2'b00};
            steps   <= steps + SCW'(1);
            if (steps == SCW'(RW - 1)) begin
                busy  <= 1'b0;
                valid <= 1'b1;
            end
        end else if (valid && take) begin
            valid <= 1'b0;
        end
    end

    // R5: a finished root is never announced while iterations remain
    p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
        !(busy && valid));
endmodule

// File: rtl/patch_corr.sv
module patch_corr
    import corr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_first,
    input  logic [1:0]    in_size,
    input  logic [15:0]   in_patch,
    input  logic [15:0]   in_proto,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [47:0]   out_dot,
    output logic [47:0]   out_energy,
    output logic [23:0]   out_root,
    output logic          out_zero
);
    logic done;
    logic taken;

    assign taken = out_valid && out_ready;

    corr_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_first  (in_first),
        .in_size   (in_size),
        .in_patch  (in_patch),
        .in_proto  (in_proto),
        .res_taken (taken),
        .in_ready  (in_ready),
        .dot       (out_dot),
        .energy    (out_energy),
        .done      (done)
    );

    corr_isqrt u_isqrt (
        .clk      (clk),
        .rst      (rst),
        .start    (done),
        .radicand (out_energy),
        .take     (out_ready),
        .valid    (out_valid),
        .root     (out_root),
        .zero     (out_zero)
    );

    logic [63:0] root_sq;
    logic [63:0] root_next_sq;
    assign root_sq      = 64'(out_root) * 64'(out_root);
    assign root_next_sq = (64'(out_root) + 64'd1) * (64'(out_root) + 64'd1);

    // R5: the reported root brackets the reported energy
    p_root_exact_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (root_sq <= 64'(out_energy)) && (root_next_sq > 64'(out_energy)));

    // R6: zero flag agrees with the energy it accompanies
    p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_zero == (out_energy == '0)));

    // R7: no new input while a result is pending
    p_ready_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R7: a stalled result holds its value
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_root)
            && $stable(out_dot) && $stable(out_energy) && $stable(out_zero));
endmodule

// File: tb/patch_corr_test.sv
module patch_corr_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_first, out_ready;
    logic [1:0]  in_size;
    logic [15:0] in_patch, in_proto;
    logic        in_ready, out_valid, out_zero;
    logic [47:0] out_dot, out_energy;
    logic [23:0] out_root;

    always #2.5 clk = ~clk;

    patch_corr uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_first(in_first), .in_size(in_size), .in_patch(in_patch),
        .in_proto(in_proto), .out_valid(out_valid), .out_ready(out_ready),
        .out_dot(out_dot), .out_energy(out_energy), .out_root(out_root),
        .out_zero(out_zero)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural model: 0 idle, 1 summing, 2 root, 3 holding
    int      m_ph = 0;
    int      m_cnt = 0, m_total = 0, m_rc = 0;
    longint  m_dot = 0, m_en = 0;

    function automatic longint isqrt_ref(longint e);
        longint r = 0;
        for (int b = 23; b >= 0; b--) begin
            longint t = r | (longint'(1) << b);
            if (t * t <= e) r = t;
        end
        return r;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // one clock: compare at negedge, then drive, then advance the model
    task automatic tick(input bit v, input bit f, input int sz, input int p,
                        input int q, input bit ordy);
        bit acc;
        @(negedge clk);
        check("R7 in_ready", longint'(in_ready), longint'(m_ph <= 1));
        check("R5 out_valid", longint'(out_valid), longint'(m_ph == 3));
        if (m_ph == 3 && out_valid) begin
            check("R3 out_dot", longint'(out_dot), m_dot);
            check("R4 out_energy", longint'(out_energy), m_en);
            check("R5 out_root", longint'(out_root), isqrt_ref(m_en));
            check("R6 out_zero", longint'(out_zero), longint'(m_en == 0));
        end
        in_valid = v; in_first = f; in_size = 2'(sz);
        in_patch = 16'(p); in_proto = 16'(q); out_ready = ordy;
        acc = v && (m_ph <= 1);
        case (m_ph)
            0: if (acc && f) begin
                int n = (sz + 1) * 4;
                m_dot = longint'(p) * q; m_en = longint'(p) * p;
                m_cnt = 1; m_total = n * n * 12; m_ph = 1;
            end
            1: if (acc) begin
                m_dot += longint'(p) * q; m_en += longint'(p) * p;
                m_cnt++;
                if (m_cnt == m_total) begin m_ph = 2; m_rc = 0; end
            end
            2: begin m_rc++; if (m_rc == 24) m_ph = 3; end
            3: if (ordy) m_ph = 0;
            default: m_ph = 0;
        endcase
    endtask

    // mode 0 random, 1 all max, 2 all zero; bubbles inserts idle cycles;
    // stray adds a mid-patch first flag with another size code
    task automatic send_patch(input int sz, input int mode, input bit bubbles, input bit stray);
        int n = (sz + 1) * 4;
        int total = n * n * 12;
        for (int i = 0; i < total; i++) begin
            int p, q;
            case (mode)
                1: begin p = 65535; q = 65535; end
                2: begin p = 0; q = int'($urandom_range(65535)); end
                default: begin p = int'($urandom_range(65535)); q = int'($urandom_range(65535)); end
            endcase
            if (bubbles && (i % 5 == 2)) tick(0, 1, 3 - sz, 777, 999, 1);
            tick(1, (i == 0) || (stray && i == 7), (i == 0) ? sz : (3 - sz), p, q, 1);
        end
    endtask

    task automatic drain(input int stall);
        int guard = 0;
        while (m_ph != 3 && guard < 100) begin
            tick(1, 1, 0, 11, 13, 1); // offered while blocked: must be refused (R7)
            guard++;
        end
        for (int k = 0; k < stall; k++) tick(1, 1, 0, 5, 5, 0);
        tick(0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        int lim = 0;
        while (lim < 150000 && !finished) begin @(posedge clk); lim++; end
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", lim);
            summary();
        end
    end

    initial begin
        rst = 1; in_valid = 0; in_first = 0; in_size = 0;
        in_patch = 0; in_proto = 0; out_ready = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1 in_ready", longint'(in_ready), 1);
        check("R1 out_valid", longint'(out_valid), 0);
        // R8: unflagged elements while idle are dropped
        tick(1, 0, 0, 1000, 1000, 1);
        tick(1, 0, 0, 2000, 3000, 1);
        // R2/R3/R4: edge 4, random data
        send_patch(0, 0, 0, 0);
        drain(0);
        // R10: edge 8 with bubbles; R7 stalled consumer
        send_patch(1, 0, 1, 0);
        drain(6);
        // R8: edge 12 with stray first flag and changing size code
        send_patch(2, 0, 0, 1);
        drain(2);
        // R3: edge 16 at full scale, no overflow
        send_patch(3, 1, 0, 0);
        drain(1);
        // R6: zero-energy patch
        send_patch(0, 2, 0, 0);
        drain(3);
        // R9: back-to-back patches, sums restart
        send_patch(0, 1, 0, 0);
        drain(0);
        send_patch(0, 0, 0, 0);
        drain(0);
        repeat (4) tick(0, 0, 0, 0, 0, 1);
        summary();
    end
endmodule